// File: doc/BRIEF.md
# Three-Operand Balanced-Ternary Adder

This block sums three signed balanced-ternary words and a signed carry-in trit. Every digit of every word is one of -1, 0 or +1. Each value's sign lives in its digits, so negative and positive operands pass through the same hardware with no sign bit. Each operand has its own negate control. When the control is set, that operand's digits are mirrored (+1 and -1 swap, 0 stays) before the addition, which turns an add into a subtract for that operand.

Inside, there is one four-input counter per digit position. A counter takes the three operand digits of its position and the carry trit from the position below. It returns a sum digit and a signed carry trit, and that carry feeds the next position. The carry out of the top position becomes the extra most significant result digit.

An optional output register gives a one-cycle latency. The register has a synchronous active-low reset.

Top module: `bt_multi_adder`

## Requirements
- R1: Each trit uses a 2-bit code: 2'b00 is 0, 2'b01 is +1 and 2'b10 is -1. An input trit coded 2'b11 (including on the carry-in) is read as 0.
- R2: The weighted value of the result equals the sum of the three operands (each after its optional negation) plus the carry-in. Trit i has weight 3^i, and trit i occupies bits [2i+1:2i].
- R3: Setting neg_i[k] negates operand k (k=0 is x_i, 1 is y_i, 2 is z_i) by swapping +1 and -1 in each of its digits. The other operands are not affected.
- R4: No output trit ever carries the code 2'b11.
- R5: The result has N_TRITS+1 trits, and the top trit is the carry out of the highest position. The extreme sums ±(3^(N_TRITS+1)-1)/2 (±121 at four trits) are represented exactly.
- R6: With REG_OUT=1, the result appears one clock after its inputs. While rst_n is low at a clock edge, the output becomes all zero trits.
- R7: Inputs held stable give an output that does not change from cycle to cycle.
- R8: Operands worth 15, -32 and 3 with a zero carry-in give a result worth -14.
- R9: The carry-in trit adds with weight 1 at the lowest position.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset of the output register |
| x_i | input | 2*N_TRITS | First operand, trit i at bits [2i+1:2i] |
| y_i | input | 2*N_TRITS | Second operand |
| z_i | input | 2*N_TRITS | Third operand |
| neg_i | input | 3 | Per-operand negate controls: bit0 x_i, bit1 y_i, bit2 z_i |
| cin_i | input | 2 | Carry-in trit at the lowest position |
| sum_o | output | 2*(N_TRITS+1) | Balanced-ternary result |

## Verification
The bench builds the block with N_TRITS=4 and REG_OUT=1. Four trits keep every operand within ±40 and every sum within ±121, so the five-trit result is fully used at both ends. Every value of a digit counter, from -4 to +4, can be reached in every position. Registered output brings in the reset value and the one-cycle latency, and lets the bench see an output that is not yet updated just before the capturing edge.

// File: rtl/bt_pkg.sv
// Package: shared trit type, code constants and digit helpers.
// Assumes trits are 2-bit codes; 2'b11 is treated as zero wherever it is read.
package bt_pkg;

    typedef logic [1:0] trit_t;

    localparam trit_t T_ZERO = 2'b00;
    localparam trit_t T_POS  = 2'b01;
    localparam trit_t T_NEG  = 2'b10;

    // Widest word the value helpers accept.
    localparam int MAX_TRITS = 16;

    // Integer worth of one trit; the unused code reads as zero.
    function automatic int trit_val(input trit_t t);
        case (t)
            T_POS:   return 1;
            T_NEG:   return -1;
            default: return 0;
        endcase
    endfunction

    // Digit-wise mirror; also maps the unused code to zero.
    function automatic trit_t trit_mirror(input trit_t t);
        case (t)
            T_POS:   return T_NEG;
            T_NEG:   return T_POS;
            default: return T_ZERO;
        endcase
    endfunction

    // Canonical code for a trit, forcing the unused code to zero.
    function automatic trit_t trit_clean(input trit_t t);
        return (t == 2'b11) ? T_ZERO : t;
    endfunction

    // Weighted value of the lowest n trits of a word.
    function automatic int word_val(input logic [2*MAX_TRITS-1:0] w, input int n);
        int acc;
        acc = 0;
        for (int i = MAX_TRITS - 1; i >= 0; i--) begin
            if (i < n) acc = acc * 3 + trit_val(w[2*i +: 2]);
        end
        return acc;
    endfunction

    // True when none of the lowest n trits uses the unused code.
    function automatic bit word_legal(input logic [2*MAX_TRITS-1:0] w, input int n);
        bit ok;
        ok = 1'b1;
        for (int i = 0; i < MAX_TRITS; i++) begin
            if (i < n && w[2*i +: 2] == 2'b11) ok = 1'b0;
        end
        return ok;
    endfunction

endpackage

// File: rtl/bt_operand_cond.sv
// Module: conditions one operand before the counter chain.
// When neg is set, every digit is mirrored (+1 <-> -1). Otherwise digits pass.
// In both cases the unused code 2'b11 leaves as zero, so downstream logic only
// ever sees legal codes.
module bt_operand_cond
    import bt_pkg::*;
#(
    parameter int N_TRITS = 4
) (
    input  logic [2*N_TRITS-1:0] raw_i,
    input  logic                 neg_i,
    output logic [2*N_TRITS-1:0] cond_o
);

    for (genvar g = 0; g < N_TRITS; g++) begin : g_digit
        // Per-digit select between the mirrored and the cleaned trit.
        always_comb begin
            if (neg_i) cond_o[2*g +: 2] = trit_mirror(raw_i[2*g +: 2]);
            else       cond_o[2*g +: 2] = trit_clean(raw_i[2*g +: 2]);
        end
    end

endmodule

// File: rtl/bt_counter4.sv
// Module: four-input balanced-ternary counter.
// Adds four legal trits (total -4..+4) and splits the total as 3*carry + digit,
// with both carry and digit in -1..+1.
module bt_counter4
    import bt_pkg::*;
(
    input  trit_t a_i,
    input  trit_t b_i,
    input  trit_t c_i,
    input  trit_t d_i,
    output trit_t digit_o,
    output trit_t carry_o
);

    int total;

    // Integer total of the four input digits.
    always_comb total = trit_val(a_i) + trit_val(b_i) + trit_val(c_i) + trit_val(d_i);

    // Split the total into the carry to the next position and the local digit.
    always_comb begin
        case (total)
            -4:      begin carry_o = T_NEG;  digit_o = T_NEG;  end
            -3:      begin carry_o = T_NEG;  digit_o = T_ZERO; end
            -2:      begin carry_o = T_NEG;  digit_o = T_POS;  end
            -1:      begin carry_o = T_ZERO; digit_o = T_NEG;  end
            1:       begin carry_o = T_ZERO; digit_o = T_POS;  end
            2:       begin carry_o = T_POS;  digit_o = T_NEG;  end
            3:       begin carry_o = T_POS;  digit_o = T_ZERO; end
            4:       begin carry_o = T_POS;  digit_o = T_POS;  end
            default: begin carry_o = T_ZERO; digit_o = T_ZERO; end
        endcase
    end

endmodule

// File: rtl/bt_ripple_chain.sv
// Module: ripple chain of four-input counters, one per digit position.
// Position g takes its three operand digits and the carry from position g-1.
// The carry out of the top position becomes result trit N_TRITS.
// Assumes all inputs already carry legal codes.
module bt_ripple_chain
    import bt_pkg::*;
#(
    parameter int N_TRITS = 4
) (
    input  logic [2*N_TRITS-1:0]     xa_i,
    input  logic [2*N_TRITS-1:0]     ya_i,
    input  logic [2*N_TRITS-1:0]     za_i,
    input  trit_t                    cin_i,
    output logic [2*(N_TRITS+1)-1:0] sum_o
);

    localparam int N_CARRY = N_TRITS + 1;

    trit_t carry [N_CARRY];

    // The carry-in enters the lowest position.
    assign carry[0] = cin_i;

    for (genvar g = 0; g < N_TRITS; g++) begin : g_pos
        bt_counter4 u_cnt (
            .a_i     (xa_i[2*g +: 2]),
            .b_i     (ya_i[2*g +: 2]),
            .c_i     (za_i[2*g +: 2]),
            .d_i     (carry[g]),
            .digit_o (sum_o[2*g +: 2]),
            .carry_o (carry[g+1])
        );
    end

    // The final carry is the top result trit.
    assign sum_o[2*N_TRITS +: 2] = carry[N_TRITS];

endmodule

// File: rtl/bt_multi_adder.sv
// Module: three-operand balanced-ternary adder with per-operand negation.
// Conditions each operand, ripples through the counter chain and, when
// REG_OUT=1, registers the result behind a synchronous active-low reset.
// Assumes rst_n is synchronous to clk.
module bt_multi_adder
    import bt_pkg::*;
#(
    parameter int N_TRITS = 4,
    parameter bit REG_OUT = 1'b1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [2*N_TRITS-1:0]     x_i,
    input  logic [2*N_TRITS-1:0]     y_i,
    input  logic [2*N_TRITS-1:0]     z_i,
    input  logic [2:0]               neg_i,
    input  logic [1:0]               cin_i,
    output logic [2*(N_TRITS+1)-1:0] sum_o
);

    localparam int N_OPS = 3;
    localparam int W_IN  = 2 * N_TRITS;
    localparam int W_OUT = 2 * (N_TRITS + 1);

    logic [W_IN-1:0]  raw  [N_OPS];
    logic [W_IN-1:0]  cond [N_OPS];
    logic [W_OUT-1:0] sum_comb;

    assign raw[0] = x_i;
    assign raw[1] = y_i;
    assign raw[2] = z_i;

    for (genvar k = 0; k < N_OPS; k++) begin : g_op
        bt_operand_cond #(.N_TRITS(N_TRITS)) u_cond (
            .raw_i  (raw[k]),
            .neg_i  (neg_i[k]),
            .cond_o (cond[k])
        );
    end

    bt_ripple_chain #(.N_TRITS(N_TRITS)) u_chain (
        .xa_i  (cond[0]),
        .ya_i  (cond[1]),
        .za_i  (cond[2]),
        .cin_i (trit_clean(cin_i)),
        .sum_o (sum_comb)
    );

    if (REG_OUT) begin : g_reg
        // Output register, cleared to all zero trits by reset.
        always_ff @(posedge clk) begin
            if (!rst_n) sum_o <= '0;
            else        sum_o <= sum_comb;
        end
    end else begin : g_comb
        assign sum_o = sum_comb;
    end

endmodule

// File: rtl/bt_multi_adder_chk.sv
// Checker: observes the adder's ports and checks value, legality, reset and
// stability over time. Attached to every bt_multi_adder by the bind below.
module bt_multi_adder_chk
    import bt_pkg::*;
#(
    parameter int N_TRITS = 4,
    parameter bit REG_OUT = 1'b1
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [2*N_TRITS-1:0]     x_i,
    input logic [2*N_TRITS-1:0]     y_i,
    input logic [2*N_TRITS-1:0]     z_i,
    input logic [2:0]               neg_i,
    input logic [1:0]               cin_i,
    input logic [2*(N_TRITS+1)-1:0] sum_o
);

    localparam int PAD_IN  = 2 * (MAX_TRITS - N_TRITS);
    localparam int PAD_OUT = 2 * (MAX_TRITS - N_TRITS - 1);

    int exp_val;
    int got_val;
    logic armed;
    logic was_rst;

    // Reference value from the arithmetic meaning of the inputs.
    always_comb begin
        exp_val = (neg_i[0] ? -1 : 1) * word_val({{PAD_IN{1'b0}}, x_i}, N_TRITS)
                + (neg_i[1] ? -1 : 1) * word_val({{PAD_IN{1'b0}}, y_i}, N_TRITS)
                + (neg_i[2] ? -1 : 1) * word_val({{PAD_IN{1'b0}}, z_i}, N_TRITS)
                + trit_val(cin_i);
        got_val = word_val({{PAD_OUT{1'b0}}, sum_o}, N_TRITS + 1);
    end

    // Tracks whether the previous edge was out of reset.
    always_ff @(posedge clk) armed <= rst_n;

    // Reset value check: the edge after a reset edge shows all-zero trits.
    always_ff @(posedge clk) begin
        if (REG_OUT && was_rst) begin
            assert_reset_zero_R6 : assert (sum_o == '0)
                else $error("sum_o not zero after reset");
        end
        was_rst <= !rst_n;
    end

    assert_legal_codes_R4 : assert property (@(posedge clk) disable iff (!rst_n)
        word_legal({{PAD_OUT{1'b0}}, sum_o}, N_TRITS + 1));

    if (REG_OUT) begin : g_reg_chk
        assert_value_R2 : assert property (@(posedge clk) disable iff (!rst_n)
            armed |-> (got_val == $past(exp_val)));

        assert_stable_R7 : assert property (@(posedge clk) disable iff (!rst_n)
            (armed && $stable(x_i) && $stable(y_i) && $stable(z_i)
                   && $stable(neg_i) && $stable(cin_i)) |=> $stable(sum_o));
    end else begin : g_comb_chk
        assert_value_R2 : assert property (@(posedge clk) disable iff (!rst_n)
            got_val == exp_val);

        assert_stable_R7 : assert property (@(posedge clk) disable iff (!rst_n)
            (armed && $stable(x_i) && $stable(y_i) && $stable(z_i)
                   && $stable(neg_i) && $stable(cin_i)) |-> $stable(sum_o));
    end

endmodule

bind bt_multi_adder bt_multi_adder_chk #(
    .N_TRITS (N_TRITS),
    .REG_OUT (REG_OUT)
) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .x_i   (x_i),
    .y_i   (y_i),
    .z_i   (z_i),
    .neg_i (neg_i),
    .cin_i (cin_i),
    .sum_o (sum_o)
);

// File: tb/bt_multi_adder_tb.sv
`timescale 1ns/1ps
// Directed bench for bt_multi_adder, built with N_TRITS=4 and REG_OUT=1.
module bt_multi_adder_tb;

    localparam int N  = 4;
    localparam int WI = 2 * N;
    localparam int WO = 2 * (N + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [WI-1:0] x = '0, y = '0, z = '0;
    logic [2:0]    neg = '0;
    logic [1:0]    cin = '0;
    logic [WO-1:0] sum;

    int checks = 0;
    int failures = 0;
    logic [15:0] lfsr = 16'hACE1;

    always #2.5 clk = ~clk;

    bt_multi_adder #(.N_TRITS(N), .REG_OUT(1'b1)) u_dut (
        .clk   (clk),
        .rst_n (rst_n),
        .x_i   (x),
        .y_i   (y),
        .z_i   (z),
        .neg_i (neg),
        .cin_i (cin),
        .sum_o (sum)
    );

    // Integer to balanced ternary, 2'b01 = +1, 2'b10 = -1, 2'b00 = 0.
    function automatic logic [2*(N+1)-1:0] enc(input int v);
        logic [2*(N+1)-1:0] w;
        int r;
        w = '0;
        for (int i = 0; i <= N; i++) begin
            r = ((v % 3) + 3) % 3;
            if (r == 1) begin w[2*i +: 2] = 2'b01; v = (v - 1) / 3; end
            else if (r == 2) begin w[2*i +: 2] = 2'b10; v = (v + 1) / 3; end
            else v = v / 3;
        end
        return w;
    endfunction

    function automatic int dec(input logic [WO-1:0] w);
        int acc;
        acc = 0;
        for (int i = N; i >= 0; i--) begin
            acc = acc * 3;
            if (w[2*i +: 2] == 2'b01) acc = acc + 1;
            else if (w[2*i +: 2] == 2'b10) acc = acc - 1;
        end
        return acc;
    endfunction

    function automatic bit legal(input logic [WO-1:0] w);
        bit ok;
        ok = 1'b1;
        for (int i = 0; i <= N; i++) if (w[2*i +: 2] == 2'b11) ok = 1'b0;
        return ok;
    endfunction

    task automatic check_int(input string req, input int got, input int exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic check_legal(input string req);
        checks++;
        if (!legal(sum)) begin
            failures++;
            $display("FAIL %s: illegal trit code in %b expected none", req, sum);
        end
    endtask

    // Drive at the falling edge, let one rising edge capture, sample at the next fall.
    task automatic apply(input int xv, input int yv, input int zv,
                         input logic [2:0] n, input logic [1:0] c);
        @(negedge clk);
        x = enc(xv)[WI-1:0];
        y = enc(yv)[WI-1:0];
        z = enc(zv)[WI-1:0];
        neg = n;
        cin = c;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        @(negedge clk);
        x = enc(13)[WI-1:0]; y = enc(5)[WI-1:0]; z = enc(-7)[WI-1:0]; cin = 2'b01;
        @(posedge clk); @(negedge clk);
        checks++;
        if (sum !== '0) begin
            failures++;
            $display("FAIL R6: reset sum %b expected all zero", sum);
        end
        rst_n = 1'b1;
    endtask

    task automatic t_example();
        apply(15, -32, 3, 3'b000, 2'b00);
        check_int("R8", dec(sum), -14);
        apply(15, 32, 3, 3'b010, 2'b00);
        check_int("R3 example via negate", dec(sum), -14);
    endtask

    task automatic t_carry_in();
        apply(0, 0, 0, 3'b000, 2'b01);
        check_int("R9 cin +1", dec(sum), 1);
        apply(0, 0, 0, 3'b000, 2'b10);
        check_int("R9 cin -1", dec(sum), -1);
        apply(0, 0, 0, 3'b000, 2'b11);
        check_int("R1 cin 11 as zero", dec(sum), 0);
        apply(1, 1, 0, 3'b000, 2'b01);
        check_int("R9 carry ripples", dec(sum), 3);
    endtask

    task automatic t_extremes();
        apply(40, 40, 40, 3'b000, 2'b01);
        check_int("R5 max", dec(sum), 121);
        check_int("R5 top trit +1", int'(sum[2*N +: 2]), 1);
        apply(40, 40, 40, 3'b111, 2'b10);
        check_int("R5 min", dec(sum), -121);
        check_int("R5 top trit -1", int'(sum[2*N +: 2]), 2);
        check_legal("R4 extremes");
    endtask

    task automatic t_negate();
        apply(13, 7, -20, 3'b001, 2'b00);
        check_int("R3 negate x only", dec(sum), -13 + 7 - 20);
        apply(13, 7, -20, 3'b100, 2'b00);
        check_int("R3 negate z only", dec(sum), 13 + 7 + 20);
        apply(0, 0, 0, 3'b111, 2'b00);
        check_int("R3 negate zero", dec(sum), 0);
    endtask

    task automatic t_illegal_in();
        @(negedge clk);
        x = 8'b01_11_00_01;          // 27 + 0 + 0 + 1 with one 11 digit
        y = enc(2)[WI-1:0];
        z = '0; neg = 3'b000; cin = 2'b00;
        @(posedge clk); @(negedge clk);
        check_int("R1 11 digit as zero", dec(sum), 30);
        check_legal("R4 after 11 input");
        @(negedge clk);
        neg = 3'b001;
        @(posedge clk); @(negedge clk);
        check_int("R1 11 digit negated", dec(sum), -26);
    endtask

    task automatic t_latency();
        apply(5, 0, 0, 3'b000, 2'b00);
        @(negedge clk);
        x = enc(-9)[WI-1:0];
        #1;
        check_int("R6 old value before edge", dec(sum), 5);
        @(posedge clk); @(negedge clk);
        check_int("R6 new value after edge", dec(sum), -9);
    endtask

    task automatic t_stable();
        apply(11, -4, 22, 3'b010, 2'b10);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check_int("R7 held inputs", dec(sum), 11 + 4 + 22 - 1);
        end
    endtask

    task automatic t_random();
        int xv, yv, zv, e;
        logic [2:0] n;
        logic [1:0] c;
        for (int k = 0; k < 300; k++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            xv = int'(lfsr % 81) - 40;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            yv = int'(lfsr % 81) - 40;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            zv = int'(lfsr % 81) - 40;
            n = lfsr[2:0];
            c = (lfsr[4:3] == 2'b11) ? 2'b00 : lfsr[4:3];
            e = (n[0] ? -xv : xv) + (n[1] ? -yv : yv) + (n[2] ? -zv : zv)
              + (c == 2'b01 ? 1 : (c == 2'b10 ? -1 : 0));
            apply(xv, yv, zv, n, c);
            check_int("R2 random sum", dec(sum), e);
            check_legal("R4 random");
        end
    endtask

    initial begin
        #(5.0 * 150000);
        failures++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (2) @(posedge clk);
        t_reset();
        t_example();
        t_carry_in();
        t_extremes();
        t_negate();
        t_illegal_in();
        t_latency();
        t_stable();
        t_random();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule